// File: doc/BRIEF.md
# Interrupt Request Latch and Priority Resolver

This block collects a group of interrupt request lines into a pending register and decides which of them, if any, should be presented to the processor. Each line is captured in one of two ways. A level-sensitive line tracks its input. An edge-sensitive line latches a rising transition and stays pending until it is explicitly cleared. The set of lines that may be switched to level sensitivity is fixed per instance by a parameter, so that lines which must stay edge-triggered cannot be reconfigured.

Pending, unmasked requests are ranked on a rotating scale. A priority offset names the line that currently holds rank 0, and rank rises by one per line from there, wrapping around. The best candidate is compared with the best line in the externally supplied in-service set, ranked on the same scale. A request is raised only when the candidate strictly outranks everything in service. In the master instance, a nested-mode flag lets the cascade line be left out of that in-service comparison, so that a further request arriving through the cascade can still get through. Command decoding and the acknowledge handshake live outside; the surrounding logic feeds the mask, the offset and the in-service set, and pulses per-line clear bits when a request is taken.

Top module: `irq_prio_resolver`

## Requirements
- R1: While `rst_n` is low, and on the first edge after its release, `req_pending_o`, `int_req_o` and `int_line_o` are all zero.
- R2: A line whose effective mode is level (`trig_mode_i[i]` = 1 and parameter bit `TRIG_ALLOW[i]` = 1) has its `req_pending_o` bit equal, after each clock edge, to the value `req_lines_i[i]` had before that edge. `req_clr_i` has no effect on it.
- R3: A line in edge mode sets its pending bit on the edge after its input goes from 0 to 1. A later low input leaves the pending bit set.
- R4: An edge-mode pending bit is cleared by `req_clr_i[i]` = 1 on an edge where no new rise is seen. A rise on the same edge wins over the clear. An input held high does not set the bit again after it has been cleared.
- R5: A line whose `TRIG_ALLOW` bit is 0 always behaves as edge mode, whatever its `trig_mode_i` bit is (default `TRIG_ALLOW` = 8'hF8, so lines 0 to 2 are edge only).
- R6: Candidates are the pending bits with their `mask_i` bit at 0. A masked line never produces `int_req_o`.
- R7: Rank p, counted from 0 (highest), belongs to line (p + `offset_i`) mod N. The winner is the candidate with the lowest rank.
- R8: `int_req_o` is raised only when the winner's rank is strictly lower than the lowest rank present in `in_service_i`. An empty in-service set counts as rank N. An equal rank gives no request.
- R9: In the master instance (`IS_MASTER` = 1) with `nested_i` = 1, bit `CASCADE_LINE` (default 2) of `in_service_i` is ignored in the R8 comparison. In every other case it counts.
- R10: `int_req_o` and `int_line_o` are registered. They reflect the pending register as it stood before the edge, together with the mask, offset, in-service and nested inputs sampled at that edge. A new request therefore appears one edge after its pending bit.
- R11: `int_line_o` carries the winning line number when `int_req_o` is 1, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_lines_i | input | N | Synchronous request line inputs |
| trig_mode_i | input | N | Per-line mode select: 1 = level, 0 = edge (gated by TRIG_ALLOW) |
| req_clr_i | input | N | Per-line clear of edge-mode pending bits |
| mask_i | input | N | Per-line mask: 1 = blocked |
| offset_i | input | $clog2(N) | Line holding rank 0 |
| in_service_i | input | N | Lines currently being serviced |
| nested_i | input | 1 | Exclude cascade line from in-service ranking (master only) |
| req_pending_o | output | N | Pending request register |
| int_req_o | output | 1 | Registered interrupt request |
| int_line_o | output | $clog2(N) | Registered winning line number |

## Verification
The bench builds the block with its defaults: eight lines, `IS_MASTER` = 1, cascade on line 2 and `TRIG_ALLOW` = 8'hF8. This mix puts forced-edge lines and selectable lines side by side, so R5 can be exercised, and it makes the nested exclusion of R9 live. Eight lines give all eight rotation offsets, so every wrap of the rank scale is swept. Random stimulus covers mask, offset and in-service patterns. Directed cases target equal ranks, the clear-versus-rise collision and a held-high edge input.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   // Per-line capture mode, as seen on trig_mode_i.
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_mode_e;

   // Default number of request lines and default cascade position.
   localparam int unsigned DEF_LINES   = 8;
   localparam int unsigned DEF_CASCADE = 2;

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
   import irq_prio_pkg::*;
#(
   parameter int unsigned N          = DEF_LINES,
   parameter logic [N-1:0] TRIG_ALLOW = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] line_i,
   input  logic [N-1:0] trig_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] req_o
);

   for (genvar i = 0; i < N; i++) begin : g_line
      logic last_q;
      logic req_bit_q;
      trig_mode_e mode;

      // Lines not allowed to be level are forced to edge mode (R5).
      assign mode = trig_mode_e'(trig_i[i] & TRIG_ALLOW[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            last_q    <= 1'b0;
            req_bit_q <= 1'b0;
         end else begin
            last_q <= line_i[i];
            if (mode == TRIG_LEVEL) begin
               req_bit_q <= line_i[i];
            end else if (line_i[i] && !last_q) begin
               req_bit_q <= 1'b1;
            end else if (clr_i[i]) begin
               req_bit_q <= 1'b0;
            end
         end
      end

      assign req_o[i] = req_bit_q;

      // R2: level lines follow the input one edge later
      a_r2_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == TRIG_LEVEL) |=> (req_bit_q == $past(line_i[i])));

      // R3: edge pending bit survives a low input when not cleared
      a_r3_edge_keeps: assert property (@(posedge clk) disable iff (!rst_n)
         ((mode == TRIG_EDGE) && req_bit_q && !clr_i[i]) |=> req_bit_q);

      // R4: a held-high edge input does not set the bit again
      a_r4_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
         ((mode == TRIG_EDGE) && last_q && line_i[i] && !req_bit_q) |=> !req_bit_q);
   end

endmodule

// File: rtl/irq_rot_scan.sv
module irq_rot_scan
   import irq_prio_pkg::*;
#(
   parameter int unsigned N = DEF_LINES,
   parameter int unsigned W = $clog2(N)
) (
   input  logic [N-1:0] vec_i,
   input  logic [W-1:0] offset_i,
   output logic [W:0]   rank_o
);

   logic [N-1:0] rot;

   // rot[p] is the line holding rank p; the W-bit sum wraps modulo N.
   for (genvar p = 0; p < N; p++) begin : g_rot
      assign rot[p] = vec_i[W'(p) + offset_i];
   end

   always_comb begin
      rank_o = (W+1)'(N);
      for (int p = N - 1; p >= 0; p--) begin
         if (rot[p]) begin
            rank_o = (W+1)'(p);
         end
      end
   end

endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
   import irq_prio_pkg::*;
#(
   parameter int unsigned N            = DEF_LINES,
   parameter bit          IS_MASTER    = 1'b1,
   parameter int unsigned CASCADE_LINE = DEF_CASCADE,
   parameter int unsigned W            = $clog2(N)
) (
   input  logic [N-1:0] pend_i,
   input  logic [N-1:0] mask_i,
   input  logic [W-1:0] offset_i,
   input  logic [N-1:0] isr_i,
   input  logic         nested_i,
   output logic         fire_o,
   output logic [W-1:0] line_o
);

   localparam logic [N-1:0] CASC_BIT = N'(1) << CASCADE_LINE;

   logic [N-1:0] cand;
   logic [N-1:0] isr_eff;
   logic [W:0]   cand_rank;
   logic [W:0]   isr_rank;

   assign cand = pend_i & ~mask_i;

   if (IS_MASTER) begin : g_master
      assign isr_eff = nested_i ? (isr_i & ~CASC_BIT) : isr_i;
   end else begin : g_slave
      logic unused_nested;
      assign unused_nested = nested_i;
      assign isr_eff = isr_i;
   end

   irq_rot_scan #(.N(N), .W(W)) u_cand_scan (
      .vec_i    (cand),
      .offset_i (offset_i),
      .rank_o   (cand_rank)
   );

   irq_rot_scan #(.N(N), .W(W)) u_isr_scan (
      .vec_i    (isr_eff),
      .offset_i (offset_i),
      .rank_o   (isr_rank)
   );

   // An empty candidate set scans to N, which is never below isr_rank.
   assign fire_o = (cand_rank < isr_rank);
   assign line_o = fire_o ? (cand_rank[W-1:0] + offset_i) : '0;

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
   import irq_prio_pkg::*;
#(
   parameter int unsigned N            = DEF_LINES,
   parameter bit          IS_MASTER    = 1'b1,
   parameter int unsigned CASCADE_LINE = DEF_CASCADE,
   parameter logic [N-1:0] TRIG_ALLOW  = N'(8'hF8),
   parameter int unsigned W            = $clog2(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_lines_i,
   input  logic [N-1:0] trig_mode_i,
   input  logic [N-1:0] req_clr_i,
   input  logic [N-1:0] mask_i,
   input  logic [W-1:0] offset_i,
   input  logic [N-1:0] in_service_i,
   input  logic         nested_i,
   output logic [N-1:0] req_pending_o,
   output logic         int_req_o,
   output logic [W-1:0] int_line_o
);

   localparam logic [N-1:0] LSB_ONE = N'(1);

   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_lines
      $error("irq_prio_resolver: N must be a power of two of at least 2");
   end
   if (CASCADE_LINE >= N) begin : g_bad_cascade
      $error("irq_prio_resolver: CASCADE_LINE out of range");
   end

   logic [N-1:0] pend_q;
   logic         fire;
   logic [W-1:0] line;
   logic         int_req_q;
   logic [W-1:0] int_line_q;

   irq_req_latch #(.N(N), .TRIG_ALLOW(TRIG_ALLOW)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (req_lines_i),
      .trig_i (trig_mode_i),
      .clr_i  (req_clr_i),
      .req_o  (pend_q)
   );

   irq_prio_core #(
      .N(N), .IS_MASTER(IS_MASTER), .CASCADE_LINE(CASCADE_LINE), .W(W)
   ) u_core (
      .pend_i   (pend_q),
      .mask_i   (mask_i),
      .offset_i (offset_i),
      .isr_i    (in_service_i),
      .nested_i (nested_i),
      .fire_o   (fire),
      .line_o   (line)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_req_q  <= 1'b0;
         int_line_q <= '0;
      end else begin
         int_req_q  <= fire;
         int_line_q <= line;
      end
   end

   assign req_pending_o = pend_q;
   assign int_req_o     = int_req_q;
   assign int_line_o    = int_line_q;

   // R11: idle output carries line zero
   a_r11_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
      !int_req_o |-> (int_line_o == '0));

   // R6: the reported line was unmasked when it was picked
   a_r6_unmasked_winner: assert property (@(posedge clk) disable iff (!rst_n)
      int_req_o |-> ((($past(mask_i) >> int_line_o) & LSB_ONE) == '0));

   // R7: the reported line was pending when it was picked
   a_r7_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
      int_req_o |-> ((($past(pend_q) >> int_line_o) & LSB_ONE) != '0));

   // R8/R9: the reported line was not itself in service, unless excluded
   a_r8_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req_o && !(IS_MASTER && $past(nested_i) && (int_line_o == W'(CASCADE_LINE))))
      |-> ((($past(in_service_i) >> int_line_o) & LSB_ONE) == '0));

endmodule

// File: tb/irq_prio_resolver_test.sv
module irq_prio_resolver_test;

   localparam int unsigned N = 8;
   localparam logic [7:0] ALLOW = 8'hF8;
   localparam int CASC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] lines = '0, trig = '0, clr = '0, mask = '0, isr = '0;
   logic [2:0] off = '0;
   logic       nested = 1'b0;
   logic [7:0] pend;
   logic       int_req;
   logic [2:0] int_line;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string tag = "R1";

   logic [7:0] m_req = '0, m_last = '0;
   logic       m_int = 1'b0;
   logic [2:0] m_line = '0;

   always #4 clk = ~clk;

   irq_prio_resolver uut (
      .clk(clk), .rst_n(rst_n), .req_lines_i(lines), .trig_mode_i(trig),
      .req_clr_i(clr), .mask_i(mask), .offset_i(off), .in_service_i(isr),
      .nested_i(nested), .req_pending_o(pend), .int_req_o(int_req),
      .int_line_o(int_line)
   );

   function automatic int rank_of(input logic [7:0] v, input int o);
      for (int p = 0; p < 8; p++) if (v[(p + o) % 8]) return p;
      return 8;
   endfunction

   task automatic model_edge();
      if (!rst_n) begin
         m_req = '0; m_last = '0; m_int = 1'b0; m_line = '0;
      end else begin
         logic [7:0] isr_e;
         int cr, ir;
         isr_e = nested ? (isr & ~(8'h1 << CASC)) : isr;
         cr = rank_of(m_req & ~mask, int'(off));
         ir = rank_of(isr_e, int'(off));
         m_int  = (cr < ir);
         m_line = m_int ? 3'((cr + int'(off)) % 8) : 3'd0;
         for (int i = 0; i < 8; i++) begin
            if (trig[i] && ALLOW[i]) m_req[i] = lines[i];
            else if (lines[i] && !m_last[i]) m_req[i] = 1'b1;
            else if (clr[i]) m_req[i] = 1'b0;
         end
         m_last = lines;
      end
   endtask

   task automatic check(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      check("pending", int'(pend), int'(m_req));
      check("int_req", int'(int_req), int'(m_int));
      check("int_line", int'(int_line), int'(m_line));
   endtask

   task automatic cycle(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         model_edge();
         @(negedge clk);
         check_all();
      end
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd1357);
      // R1: reset state
      tag = "R1";
      cycle(3);
      rst_n = 1'b1;
      cycle(1);

      // R2: level line follows input
      tag = "R2"; trig = 8'hF8; lines = 8'h20;
      cycle(2);
      lines = 8'h00; clr = 8'h20;
      cycle(2);
      clr = 8'h00;

      // R3: edge capture survives low input
      tag = "R3"; lines = 8'h02;
      cycle(1);
      lines = 8'h00;
      cycle(3);

      // R4: clear, rise-over-clear, held-high no retrigger
      tag = "R4"; clr = 8'h02;
      cycle(1);
      clr = 8'h01; lines = 8'h01;
      cycle(1);
      cycle(1);
      clr = 8'h00;
      cycle(2);
      lines = 8'h00;
      cycle(1);

      // R5: forced-edge line ignores level select
      tag = "R5"; trig = 8'hFF; lines = 8'h04;
      cycle(1);
      lines = 8'h00;
      cycle(2);
      clr = 8'hFF;
      cycle(1);
      clr = 8'h00;

      // R6: masked line never wins
      tag = "R6"; trig = 8'hF8; lines = 8'h40; mask = 8'h40;
      cycle(3);
      mask = 8'h00;
      cycle(2);

      // R7: rotating ranks over every offset
      tag = "R7"; lines = 8'hA8;
      for (int o = 0; o < 8; o++) begin
         off = 3'(o);
         cycle(2);
      end
      off = 3'd0;

      // R8: strict comparison with in-service set
      tag = "R8"; lines = 8'h28;
      isr = 8'h08; cycle(2);
      isr = 8'h20; cycle(2);
      lines = 8'h08; isr = 8'h08; cycle(2);
      isr = 8'h00; cycle(2);

      // R9: nested mode drops cascade from in-service ranking
      tag = "R9"; lines = 8'h04; cycle(1); lines = 8'h00;
      isr = 8'h04; nested = 1'b0; cycle(2);
      nested = 1'b1; cycle(2);
      nested = 1'b0; isr = 8'h00; clr = 8'hFF; cycle(1); clr = 8'h00;

      // R10: output appears one edge after the pending bit
      tag = "R10"; lines = 8'h80; cycle(1);
      lines = 8'h00; cycle(2);

      // R11 with R6 R7 R8 R9: random mix
      tag = "R11 random";
      for (int n = 0; n < 400; n++) begin
         lines  = 8'($urandom);
         trig   = 8'($urandom);
         clr    = 8'($urandom & $urandom);
         mask   = 8'($urandom & $urandom);
         off    = 3'($urandom);
         isr    = 8'($urandom & $urandom & $urandom);
         nested = 1'($urandom);
         cycle(1);
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

endmodule